// File: doc/BRIEF.md
# Shift-Register Programmable Clock Divider

This block produces one output pulse for every N+2 cycles of its input clock, where N is a binary value on a select input. It does so without a counter or a comparator. A chain of flip-flops fills with ones, one new stage per rising clock edge, starting from stage 0. The stage picked by N feeds a feedback flip-flop that samples on the falling clock edge. When that flip-flop captures a one, it drives the chain's clear, and the next rising edge empties the whole chain. On the following falling edge the feedback flip-flop captures a zero, which lets the chain start filling again. The pulse train on the output is the feedback flip-flop itself.

The block is meant for slow, adjustable strobes derived from a fast clock. N may be changed at any time. The new ratio is in force from the first complete output period after the change. Each output pulse is one input clock period wide and the duty cycle is not corrected.

Top module: `shiftreg_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` is low and every stage of the chain is zero. The reset is asynchronous and active low.
- R2: On each rising clock edge at which the clear is inactive, a logic 1 enters stage 0 and every stage takes the value of the stage below it. The chain therefore always holds a contiguous run of ones that starts at stage 0.
- R3: The chain is tapped at stage index N, where N is `ratio_sel` read as an unsigned binary number. A 1 reaches the tap on the (N+1)-th rising edge after the clear is released.
- R4: The feedback flip-flop samples the tap on the falling clock edge, and `div_out` follows that sample.
- R5: While `div_out` is high, the next rising edge clears every stage of the chain to zero.
- R6: With N held constant, successive rising edges of `div_out` are exactly N+2 input clock periods apart, for every N from 0 to 2^NW-1.
- R7: `div_out` stays high for exactly one input clock period, from one falling edge to the next.
- R8: The extreme settings give valid ratios: N=0 divides by 2, and N=2^NW-1 divides by 2^NW+1.
- R9: After `ratio_sel` changes, the first complete output period that follows already has the length N+2 for the new N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; the chain uses the rising edge and the feedback flip-flop uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | NW | Tap index N; the division ratio is N+2 |
| div_out | output | 1 | Divided pulse train, one clock period high per N+2 clocks |

## Verification
Every value of N is applied in turn and the spacing of output rising edges is measured. This separates an off-by-one in the tap from one in the clear path, and the sweep reaches both the shortest ratio of 2 and the longest chain. Changes of N made part-way through a fill are tried in both directions. Lowering N below the current fill level shows whether the tap is re-selected at once. Raising it shows whether the fill simply continues. A reset asserted mid-period shows that the output and the fill restart cleanly. A behavioural fill-level model is compared with the output on every clock, so a pulse that is wide, late or missing is caught even where the period happens to look right.

// File: rtl/divn_pkg.sv
package divn_pkg;

  // Number of chain stages needed so that every N code selects a real stage.
  function automatic int stage_count(input int nw);
    return 1 << nw;
  endfunction

  // Clocks from clear release until the selected stage holds a one.
  function automatic int fill_time(input int n);
    return n + 1;
  endfunction

  // Input clocks per output period for tap index n.
  function automatic int ratio_for(input int n);
    return fill_time(n) + 1;
  endfunction

endpackage

// File: rtl/divn_stage_chain.sv
module divn_stage_chain #(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [DEPTH-1:0] stages
);

  // Each stage is its own flop; stage 0 always loads a constant one.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic d_in;
    if (i == 0) begin : g_head
      assign d_in = 1'b1;
    end else begin : g_body
      assign d_in = stages[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stages[i] <= 1'b0;
      end else if (clr) begin
        stages[i] <= 1'b0;
      end else begin
        stages[i] <= d_in;
      end
    end
  end

endmodule

// File: rtl/divn_tap_select.sv
module divn_tap_select #(
  parameter int NW    = 6,
  parameter int DEPTH = 64
) (
  input  logic [DEPTH-1:0] stages,
  input  logic [NW-1:0]    sel,
  output logic             tap
);

  logic [DEPTH-1:0] hit;

  // One-hot AND-OR selection keeps the depth at one decode plus an OR tree.
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = stages[i] & (sel == NW'(i));
  end

  assign tap = |hit;

endmodule

// File: rtl/divn_feedback.sv
module divn_feedback (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  output logic fb
);

  // Falling-edge capture gives the chain half a period to settle before the clear.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb <= 1'b0;
    end else begin
      fb <= tap;
    end
  end

endmodule

// File: rtl/shiftreg_divider.sv
module shiftreg_divider #(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] ratio_sel,
  output logic          div_out
);

  import divn_pkg::*;

  localparam int DEPTH = stage_count(NW);

  // Named internal events, observed by the bound checker.
  logic [DEPTH-1:0] fill_vec;
  logic             tap_bit;
  logic             clear_req;

  divn_stage_chain #(
    .DEPTH (DEPTH)
  ) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clear_req),
    .stages (fill_vec)
  );

  divn_tap_select #(
    .NW    (NW),
    .DEPTH (DEPTH)
  ) u_tap (
    .stages (fill_vec),
    .sel    (ratio_sel),
    .tap    (tap_bit)
  );

  divn_feedback u_fb (
    .clk   (clk),
    .rst_n (rst_n),
    .tap   (tap_bit),
    .fb    (clear_req)
  );

  assign div_out = clear_req;

endmodule

// File: rtl/shiftreg_divider_chk.sv
module shiftreg_divider_chk #(
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] fill_vec,
  input logic             tap_bit,
  input logic             div_out
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!div_out && fill_vec == '0)); // R1

  AST_HEAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !div_out |=> fill_vec[0]); // R2

  AST_CONTIGUOUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vec & (fill_vec + DEPTH'(1))) == '0); // R2

  AST_TAP_CAPTURED: assert property (@(negedge clk) disable iff (!rst_n)
    tap_bit |=> div_out); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> (fill_vec == '0)); // R5

  AST_PULSE_ONE_CLOCK: assert property (@(negedge clk) disable iff (!rst_n)
    div_out |=> !div_out); // R7

endmodule

bind shiftreg_divider shiftreg_divider_chk #(
  .DEPTH (DEPTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fill_vec (fill_vec),
  .tap_bit  (tap_bit),
  .div_out  (div_out)
);

// File: tb/shiftreg_divider_bench.sv
module shiftreg_divider_bench;

  localparam int NW    = 6;
  localparam int DEPTH = 1 << NW;
  localparam int WATCHDOG_NS = 3_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] ratio_sel = '0;
  logic          div_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state: count of ones in the chain, and the expected output.
  int fill_level = 0;
  bit exp_out    = 0;

  shiftreg_divider #(.NW(NW)) u_shiftreg_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .div_out   (div_out)
  );

  always #10 clk = ~clk;

  function automatic int expected_ratio(input int n);
    return 2 + n;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Model: rising edge grows or empties the fill, falling edge compares it to N.
  always @(posedge clk) begin
    if (!rst_n || exp_out) fill_level = 0;
    else if (fill_level < DEPTH) fill_level = fill_level + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) exp_out = 0;
    else exp_out = (fill_level > int'(ratio_sel));
    #5;
    if (!done) check("R3 R4 R5 per-cycle output", int'(div_out), int'(exp_out));
  end

  // Waits (from a sample point) for the next rising edge of div_out; returns clocks elapsed.
  task automatic next_rise(output int cycles);
    bit was;
    was = div_out;
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      #5;
      if (div_out && !was) break;
      was = div_out;
    end
  endtask

  task automatic step_to_sample();
    @(posedge clk);
    @(negedge clk);
    #5;
  endtask

  initial begin
    #(WATCHDOG_NS);
    bad++;
    total++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int p;
    int d;
    // R1: held in reset, output low
    repeat (3) step_to_sample();
    check("R1 reset output", int'(div_out), 0);
    rst_n = 1'b1;
    ratio_sel = NW'(4);
    // R3: first pulse after N+1 fills
    next_rise(p);
    check("R3 first pulse delay", p, 4 + 1);

    // R6 / R7 / R8: sweep every N
    for (int n = 0; n < DEPTH; n++) begin
      ratio_sel = NW'(n);
      next_rise(d);
      next_rise(d);
      next_rise(p);
      if (n == 0 || n == DEPTH - 1) check("R8 extreme ratio", p, expected_ratio(n));
      else check("R6 ratio sweep", p, expected_ratio(n));
      step_to_sample();
      check("R7 pulse width one clock", int'(div_out), 0);
    end

    // R9: lower N below the current fill mid-period
    ratio_sel = NW'(50);
    next_rise(d);
    repeat (30) step_to_sample();
    ratio_sel = NW'(3);
    next_rise(d);
    next_rise(p);
    check("R9 change downward", p, expected_ratio(3));

    // R9: raise N mid-period
    ratio_sel = NW'(5);
    next_rise(d);
    repeat (2) step_to_sample();
    ratio_sel = NW'(40);
    next_rise(d);
    next_rise(p);
    check("R9 change upward", p, expected_ratio(40));

    // R1: reset mid-period clears output at once and restarts the fill
    ratio_sel = NW'(10);
    next_rise(d);
    repeat (4) step_to_sample();
    rst_n = 1'b0;
    #1;
    check("R1 async reset output", int'(div_out), 0);
    #4;
    repeat (2) step_to_sample();
    rst_n = 1'b1;
    next_rise(p);
    check("R1 R3 restart after reset", p, 10 + 1);
    next_rise(p);
    check("R6 ratio after reset", p, expected_ratio(10));

    finish_run();
  end

endmodule